// File: doc/BRIEF.md
# Two-Level Lookahead 16-Bit Adder

A purely combinational 16-bit binary adder that avoids a long carry chain by resolving carries in two lookahead levels. The operands are cut into four 4-bit slices. Each slice forms a generate bit (both operand bits high) and a propagate bit (operand bits differ) for each of its positions. It derives its three inner carries from flat sum-of-products terms of those bits and its own carry-in. It also reports a slice-wide generate and a slice-wide propagate.

A second lookahead stage, built from the very same carry function as the one inside each slice, takes the four slice-wide signals and the block carry-in and produces the carry-in of every upper slice directly. No slice ever waits on the carry-out of the slice below. The adder is dropped into any datapath that needs `{carry, sum} = a + b + cin` in a single combinational level of logic.

Top module: `cla16_2lvl`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, settling in the same time step as the inputs change, with no clock involved.
- R2: `cout_o` equals bit 16 of `a_i + b_i + cin_i`.
- R3: When every bit position of a slice has differing operand bits, the carry leaving that slice equals the carry entering it. With a=0xFFFF and b=0x0000, cin=1 gives sum 0x0000 and cout 1, and cin=0 gives sum 0xFFFF and cout 0.
- R4: A slice whose own bits generate a carry delivers a carry of 1 to the next slice, whatever its carry-in. Such a slice never also reports full propagation.
- R5: The carry entering each slice boundary, at bits 4, 8 and 12, equals the carry of adding all lower bits with cin. It is visible as a sum bit at that boundary.
- R6: Full-scale operands with carry-in, a=b=0xFFFF and cin=1, give sum 0xFFFF and cout 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the total |
| cout_o | output | 1 | Carry out of bit 15 |

## Verification
The checks evaluate whenever an input changes. They assume that all inputs hold known 0/1 values and that each input change is allowed to settle before the outputs are read. The bench drives every operand set as one change on the falling clock edge and reads the outputs a nanosecond later. No input ever moves while a check is pending. The stimulus covers whole-slice propagation, slice-level generation, boundary carries and random operand pairs.

// File: rtl/cla16_2lvl.sv
module cla16_2lvl (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        cin_i,
  output logic [15:0] sum_o,
  output logic        cout_o
);

  // Returns {gen_all, c3, c2, c1}; gen_all excludes the c0 term.
  function automatic logic [3:0] look4(input logic [3:0] p, input logic [3:0] g, input logic c0);
    logic [3:0] r;
    r[0] = g[0] | p[0] & c0;
    r[1] = g[1] | p[1] & g[0] | p[1] & p[0] & c0;
    r[2] = g[2] | p[2] & g[1] | p[2] & p[1] & g[0] | p[2] & p[1] & p[0] & c0;
    r[3] = g[3] | p[3] & g[2] | p[3] & p[2] & g[1] | p[3] & p[2] & p[1] & g[0];
    return r;
  endfunction

  logic [3:0] grp_p;
  logic [3:0] grp_g;
  logic [3:0] slc_c;
  logic [3:0] top_la;

  assign top_la = look4(grp_p, grp_g, cin_i);
  assign slc_c  = {top_la[2:0], cin_i};
  assign cout_o = top_la[3] | (&grp_p & cin_i);

  for (genvar k = 0; k < 4; k++) begin : g_slice
    logic [3:0] p;
    logic [3:0] g;
    logic [3:0] la;
    logic [3:0] cy;

    assign p  = a_i[4*k +: 4] ^ b_i[4*k +: 4];
    assign g  = a_i[4*k +: 4] & b_i[4*k +: 4];
    assign la = look4(p, g, slc_c[k]);
    assign cy = {la[2:0], slc_c[k]};

    assign grp_p[k] = &p;
    assign grp_g[k] = la[3];
    assign sum_o[4*k +: 4] = p ^ cy;
  end

endmodule

module cla16_2lvl_chk (
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic        cin_i,
  input logic [15:0] sum_o,
  input logic        cout_o,
  input logic [3:0]  grp_p,
  input logic [3:0]  grp_g,
  input logic [3:0]  slc_c
);

  logic [16:0] ref_total;
  logic [3:0]  c_next;

  assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {16'd0, cin_i};
  assign c_next    = {cout_o, slc_c[3:1]};

  always_comb begin
    p_sum_r1: assert (sum_o == ref_total[15:0]);
    p_cout_r2: assert (cout_o == ref_total[16]);
  end

  for (genvar k = 0; k < 4; k++) begin : g_chk
    always_comb begin
      p_pass_r3: assert (!grp_p[k] || c_next[k] == slc_c[k]);
      p_gen_r4: assert (!grp_g[k] || c_next[k]);
      p_excl_r4: assert (!(grp_p[k] && grp_g[k]));
      p_edge_r5: assert (slc_c[k] == (a_i[4*k] ^ b_i[4*k] ^ ref_total[4*k]));
    end
  end

endmodule

bind cla16_2lvl cla16_2lvl_chk u_chk (
  .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .sum_o(sum_o), .cout_o(cout_o),
  .grp_p(grp_p), .grp_g(grp_g), .slc_c(slc_c)
);

// File: tb/cla16_2lvl_tb.sv
`timescale 1ns/1ps
module cla16_2lvl_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] a, b, sum;
  logic        cin, cout;
  int n_run = 0;
  int n_fail = 0;

  cla16_2lvl u_dut (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout));

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h cin=%0d actual=%h expected=%h", req, a, b, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] av, input logic [15:0] bv, input logic cv);
    @(negedge clk);
    a = av; b = bv; cin = cv;
    #1;
  endtask

  task automatic add_chk(input string req, input logic [15:0] av, input logic [15:0] bv, input logic cv);
    logic [16:0] exp;
    apply(av, bv, cv);
    exp = {1'b0, av} + {1'b0, bv} + {16'd0, cv};
    chk({req, " R1 sum"}, {1'b0, sum}, {1'b0, exp[15:0]});
    chk({req, " R2 cout"}, {16'd0, cout}, {16'd0, exp[16]});
  endtask

  task automatic t_idle;
    apply(16'h0000, 16'h0000, 1'b0);
    chk("R1 idle zero", {cout, sum}, 17'h00000);
  endtask

  task automatic t_full_scale;
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    chk("R6 full scale", {cout, sum}, 17'h1FFFF);
    apply(16'hFFFF, 16'hFFFF, 1'b0);
    chk("R6 full scale no cin", {cout, sum}, 17'h1FFFE);
  endtask

  task automatic t_propagate;
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R3 chain cin1", {cout, sum}, 17'h10000);
    apply(16'hFFFF, 16'h0000, 1'b0);
    chk("R3 chain cin0", {cout, sum}, 17'h0FFFF);
    apply(16'h0F0F, 16'hF0F0, 1'b1);
    chk("R3 mixed chain", {cout, sum}, 17'h10000);
  endtask

  task automatic t_generate;
    apply(16'h0008, 16'h0008, 1'b0);
    chk("R4 slice0 gen", {cout, sum}, 17'h00010);
    apply(16'h00F8, 16'h0008, 1'b0);
    chk("R4 gen through slice1", {cout, sum}, 17'h00100);
    apply(16'h8000, 16'h8000, 1'b1);
    chk("R4 top gen", {cout, sum}, 17'h10001);
  endtask

  task automatic t_boundary;
    apply(16'h000F, 16'h0001, 1'b0);
    chk("R5 edge bit4", {cout, sum}, 17'h00010);
    apply(16'h00FF, 16'h0000, 1'b1);
    chk("R5 edge bit8", {cout, sum}, 17'h00100);
    apply(16'h0FFF, 16'h0001, 1'b0);
    chk("R5 edge bit12", {cout, sum}, 17'h01000);
  endtask

  task automatic t_alternating;
    add_chk("alt 5/A", 16'h5555, 16'hAAAA, 1'b0);
    add_chk("alt 5/A cin", 16'h5555, 16'hAAAA, 1'b1);
    add_chk("alt A/A", 16'hAAAA, 16'hAAAA, 1'b1);
    add_chk("alt 5/5", 16'h5555, 16'h5555, 1'b0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 10000; i++)
      add_chk("rand", 16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    t_idle();
    t_full_scale();
    t_propagate();
    t_generate();
    t_boundary();
    t_alternating();
    t_random();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule